// File: doc/BRIEF.md
# Two-Tick Pipelined Register-Memory Core

This block is a small 32-bit processor core that executes out of a single 512-word memory. The same memory holds code and data, so a program may rewrite its own instruction words. Each instruction is overlapped with its neighbours across three two-tick slots: fetch, decode with operand read, and execute with writeback. One instruction therefore completes every two clock ticks.

The instruction set is deliberately tiny: a copy, an add, two field-insert operations, a no-op, a stop, and a repeat instruction that loops a block of instructions with no lost slots. Results are forwarded to the operands of the next instruction, but never to the fetch path. A rewritten instruction word therefore only takes effect for the third instruction after the writer. Programs can exploit this to build two-instruction stride-copy loops that patch their own address fields.

Memory is loaded through a preload port while reset is held, and any word can be observed on a debug read port. The core starts fetching at address 0 when reset is released.

Top module: `pipe_regcore`

## Requirements
- R1: While rst_n is low, a word on pl_data is written to address pl_addr on each rising edge with pl_we high. halt reads 0, and dbg_data always shows the current content of word dbg_addr.
- R2: Each instruction takes one slot of two ticks. If N instructions are issued before a stop instruction (each loop pass counted), halt rises at the rising edge numbered 2N+6 after reset release, and not earlier.
- R3: Instruction format: opcode in bits 31:27, immediate flag in bit 18, destination field in bits 17:9, source field in bits 8:0. Opcodes: 0 no-op, 1 copy, 2 add, 3 set-source-field, 4 set-destination-field, 5 repeat, 6 stop. Copy writes S to word D and add writes D+S to word D. S is the word at the source address, or the zero-extended source field when bit 18 is 1.
- R4: Set-source-field replaces bits 8:0 of word D with bits 8:0 of S. Set-destination-field replaces bits 17:9 of word D with bits 8:0 of S. All other bits of word D are kept.
- R5: An instruction that reads a word written by the instruction just before it sees the new value.
- R6: When an instruction writes a word that is later fetched as an instruction, the first and second instructions issued after the writer execute the old form. The third and later execute the new form.
- R7: Repeat with destination field L and count S (low 16 bits) runs the next L instructions S times, and once when S is 0. Each loop pass costs exactly its instruction slots.
- R8: After the stop instruction executes, halt stays high until reset, and no further memory word changes. The instruction stored after the stop has no effect.
- R9: A repeat body consisting of a copy and an add of the word (1<<9)+8 to that copy performs a gather, provided it is preceded by one lead-in add. The result is dst[k] = src[8k] for all k. Without the lead-in add, the first element is copied twice and the last is never copied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset; also enables preload |
| pl_we | input | 1 | Preload write enable, honoured only in reset |
| pl_addr | input | 9 | Preload word address |
| pl_data | input | 32 | Preload word value |
| halt | output | 1 | High once the stop instruction has executed |
| dbg_addr | input | 9 | Debug read address |
| dbg_data | output | 32 | Content of word dbg_addr |

## Verification
The core is driven with several programs:
- A stride gather with the lead-in add, and the same gather without it. The pair distinguishes correct fetch latency from fetch forwarding, which would skip elements, and from a one-slot-longer latency, which would shift differently.
- A back-to-back read-after-write chain, which isolates operand forwarding.
- A self-patching program that rewrites the instructions two and three slots ahead, which pins the exact visibility boundary.
- A program with a zero-count repeat, a one-instruction block, a memory-sourced count and field inserts on all-ones words, which covers loop edge cases, field masking and the no-effect word after the stop.

Every run is compared against a behavioural model on every clock for the stop timing, and over the whole memory at the end.

// File: rtl/rc_pkg.sv
// Shared opcode encoding and field widths for the pipelined register-memory core.
package rc_pkg;
    localparam int OPC_W = 5;

    typedef enum logic [OPC_W-1:0] {
        OP_NOP  = 5'd0,
        OP_MOV  = 5'd1,
        OP_ADD  = 5'd2,
        OP_SETS = 5'd3,
        OP_SETD = 5'd4,
        OP_REP  = 5'd5,
        OP_HALT = 5'd6
    } opcode_e;
endpackage

// File: rtl/rc_mem.sv
// Unified code/data word store.
// Four combinational read ports (fetch, destination operand, source operand,
// debug) and one write port. Preload writes are accepted only while reset is
// held; core writes only outside reset. Contents are not cleared by reset.
module rc_mem #(
    parameter int AW = 9,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pl_we,
    input  logic [AW-1:0] pl_addr,
    input  logic [DW-1:0] pl_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] f_addr,
    output logic [DW-1:0] f_data,
    input  logic [AW-1:0] d_addr,
    output logic [DW-1:0] d_data,
    input  logic [AW-1:0] s_addr,
    output logic [DW-1:0] s_data,
    input  logic [AW-1:0] g_addr,
    output logic [DW-1:0] g_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] words [DEPTH];

    // Single write port: preload during reset, core writeback otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if (pl_we) words[pl_addr] <= pl_data;
        end else if (wr_en) begin
            words[wr_addr] <= wr_data;
        end
    end

    // Asynchronous reads; a same-edge write is seen only after the edge.
    always_comb begin
        f_data = words[f_addr];
        d_data = words[d_addr];
        s_data = words[s_addr];
        g_data = words[g_addr];
    end
endmodule

// File: rtl/rc_fetch.sv
// Fetch stage with the zero-overhead loop sequencer.
// Advances once per slot (adv). A repeat in decode overrides the loop
// registers in the same slot, so the instruction after it already loops.
// Assumes the repeat is not itself the last word of an enclosing block.
module rc_fetch #(
    parameter int AW = 9,
    parameter int DW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          stop,
    input  logic [DW-1:0] fetch_data,
    input  logic          rep_set,
    input  logic [AW-1:0] rep_start,
    input  logic [AW-1:0] rep_end,
    input  logic [LW-1:0] rep_left,
    output logic [AW-1:0] pc,
    output logic [DW-1:0] f_word,
    output logic [AW-1:0] f_pc,
    output logic          f_valid,
    output logic [LW-1:0] loop_left
);
    logic [AW-1:0] loop_start, loop_end;
    logic [AW-1:0] eff_start, eff_end;
    logic [LW-1:0] eff_left;

    // Pick loop bounds: a repeat now in decode wins over the held ones.
    always_comb begin
        eff_start = rep_set ? rep_start : loop_start;
        eff_end   = rep_set ? rep_end   : loop_end;
        eff_left  = rep_set ? rep_left  : loop_left;
    end

    // Latch the fetched word and choose the next fetch address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc         <= '0;
            f_word     <= '0;
            f_pc       <= '0;
            f_valid    <= 1'b0;
            loop_left  <= '0;
            loop_start <= '0;
            loop_end   <= '0;
        end else if (adv) begin
            if (stop) begin
                f_valid <= 1'b0;
            end else begin
                f_word     <= fetch_data;
                f_pc       <= pc;
                f_valid    <= 1'b1;
                loop_start <= eff_start;
                loop_end   <= eff_end;
                if (pc == eff_end && eff_left != '0) begin
                    pc        <= eff_start;
                    loop_left <= eff_left - 1'b1;
                end else begin
                    pc        <= pc + 1'b1;
                    loop_left <= eff_left;
                end
            end
        end
    end
endmodule

// File: rtl/rc_operand.sv
// Decode-slot operand read and latch into the execute slot.
// Operands come from memory unless the instruction in execute is writing the
// same word this slot, in which case its result is forwarded.
module rc_operand #(
    parameter int AW = 9,
    parameter int DW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv,
    input  logic                 d_valid,
    input  rc_pkg::opcode_e      d_op,
    input  logic                 d_imm,
    input  logic [AW-1:0]        d_daddr,
    input  logic [AW-1:0]        d_saddr,
    input  logic [DW-1:0]        dmem,
    input  logic [DW-1:0]        smem,
    input  logic                 fwd_en,
    input  logic [AW-1:0]        fwd_addr,
    input  logic [DW-1:0]        fwd_data,
    output logic [DW-1:0]        d_sval,
    output logic                 e_valid,
    output rc_pkg::opcode_e      e_op,
    output logic [AW-1:0]        e_daddr,
    output logic [DW-1:0]        e_dval,
    output logic [DW-1:0]        e_sval
);
    logic [DW-1:0] d_dval;

    // Operand selection with writeback forwarding.
    always_comb begin
        d_dval = (fwd_en && fwd_addr == d_daddr) ? fwd_data : dmem;
        if (d_imm)
            d_sval = {{(DW-AW){1'b0}}, d_saddr};
        else if (fwd_en && fwd_addr == d_saddr)
            d_sval = fwd_data;
        else
            d_sval = smem;
    end

    // Hand the decoded instruction and its operands to execute.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_valid <= 1'b0;
            e_op    <= rc_pkg::OP_NOP;
            e_daddr <= '0;
            e_dval  <= '0;
            e_sval  <= '0;
        end else if (adv) begin
            e_valid <= d_valid;
            e_op    <= d_op;
            e_daddr <= d_daddr;
            e_dval  <= d_dval;
            e_sval  <= d_sval;
        end
    end
endmodule

// File: rtl/rc_alu.sv
// Execute-slot result computation. Purely combinational; says whether the
// instruction writes its destination word and with what value.
module rc_alu #(
    parameter int AW = 9,
    parameter int DW = 32
) (
    input  rc_pkg::opcode_e op,
    input  logic [DW-1:0]   dval,
    input  logic [DW-1:0]   sval,
    output logic            writes,
    output logic [DW-1:0]   result
);
    // Result per opcode; field inserts keep all bits outside the field.
    always_comb begin
        writes = 1'b1;
        result = dval;
        case (op)
            rc_pkg::OP_MOV:  result = sval;
            rc_pkg::OP_ADD:  result = dval + sval;
            rc_pkg::OP_SETS: result[AW-1:0] = sval[AW-1:0];
            rc_pkg::OP_SETD: result[2*AW-1:AW] = sval[AW-1:0];
            default:         writes = 1'b0;
        endcase
    end
endmodule

// File: rtl/pipe_regcore.sv
// Top of the pipelined register-memory core.
// One slot = two ticks (phase 0, phase 1); all stages advance at the end of
// phase 1. Fetch -> decode/operand -> execute/writeback. Writeback is
// forwarded to operands only, never to fetch. Assumes memory is preloaded
// during reset and execution starts at word 0.
module pipe_regcore #(
    parameter int AW = 9,
    parameter int DW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pl_we,
    input  logic [AW-1:0] pl_addr,
    input  logic [DW-1:0] pl_data,
    output logic          halt,
    input  logic [AW-1:0] dbg_addr,
    output logic [DW-1:0] dbg_data
);
    import rc_pkg::*;

    localparam int IMM_BIT = 2 * AW;

    logic            phase, adv, stopped, stop;
    logic [AW-1:0]   pc, f_pc;
    logic [DW-1:0]   fetch_data, d_word, dmem, smem, d_sval;
    logic            d_valid, d_imm;
    opcode_e         d_op;
    logic [AW-1:0]   d_daddr, d_saddr;
    logic            rep_set;
    logic [AW-1:0]   rep_start, rep_end;
    logic [LW-1:0]   rep_left, rep_cnt, loop_left;
    logic            e_valid;
    opcode_e         e_op;
    logic [AW-1:0]   e_daddr;
    logic [DW-1:0]   e_dval, e_sval, alu_res;
    logic            alu_writes, wr_en;
    logic [AW-1:0]   wr_addr;
    logic [DW-1:0]   wr_data;

    // Slot phase toggles every tick until the core halts.
    always_ff @(posedge clk) begin
        if (!rst_n)     phase <= 1'b0;
        else if (!halt) phase <= ~phase;
    end

    // Field split of the instruction in decode.
    always_comb begin
        adv       = phase && !halt;
        d_op      = opcode_e'(d_word[DW-1 -: OPC_W]);
        d_imm     = d_word[IMM_BIT];
        d_daddr   = d_word[2*AW-1:AW];
        d_saddr   = d_word[AW-1:0];
        rep_set   = d_valid && d_op == OP_REP;
        rep_start = f_pc + 1'b1;
        rep_end   = f_pc + d_daddr;
        rep_cnt   = d_sval[LW-1:0];
        rep_left  = (rep_cnt == '0) ? '0 : rep_cnt - 1'b1;
        stop      = stopped || (d_valid && d_op == OP_HALT);
        wr_en     = adv && e_valid && alu_writes;
        wr_addr   = e_daddr;
        wr_data   = alu_res;
    end

    // Stop flags: fetch freezes once a stop is decoded, halt once it executes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stopped <= 1'b0;
            halt    <= 1'b0;
        end else if (adv) begin
            if (d_valid && d_op == OP_HALT) stopped <= 1'b1;
            if (e_valid && e_op == OP_HALT) halt    <= 1'b1;
        end
    end

    rc_mem #(.AW(AW), .DW(DW)) i_mem (
        .clk(clk), .rst_n(rst_n),
        .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .f_addr(pc), .f_data(fetch_data),
        .d_addr(d_daddr), .d_data(dmem),
        .s_addr(d_saddr), .s_data(smem),
        .g_addr(dbg_addr), .g_data(dbg_data)
    );

    rc_fetch #(.AW(AW), .DW(DW), .LW(LW)) i_fetch (
        .clk(clk), .rst_n(rst_n), .adv(adv), .stop(stop),
        .fetch_data(fetch_data),
        .rep_set(rep_set), .rep_start(rep_start), .rep_end(rep_end),
        .rep_left(rep_left),
        .pc(pc), .f_word(d_word), .f_pc(f_pc), .f_valid(d_valid),
        .loop_left(loop_left)
    );

    rc_operand #(.AW(AW), .DW(DW)) i_operand (
        .clk(clk), .rst_n(rst_n), .adv(adv),
        .d_valid(d_valid), .d_op(d_op), .d_imm(d_imm),
        .d_daddr(d_daddr), .d_saddr(d_saddr),
        .dmem(dmem), .smem(smem),
        .fwd_en(wr_en), .fwd_addr(wr_addr), .fwd_data(wr_data),
        .d_sval(d_sval),
        .e_valid(e_valid), .e_op(e_op), .e_daddr(e_daddr),
        .e_dval(e_dval), .e_sval(e_sval)
    );

    rc_alu #(.AW(AW), .DW(DW)) i_alu (
        .op(e_op), .dval(e_dval), .sval(e_sval),
        .writes(alu_writes), .result(alu_res)
    );
endmodule

// File: rtl/rc_checker.sv
// Protocol checks for pipe_regcore, attached through bind.
module rc_checker #(
    parameter int AW = 9,
    parameter int DW = 32,
    parameter int LW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          phase,
    input logic          halt,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          d_valid,
    input logic          d_imm,
    input logic [AW-1:0] d_saddr,
    input logic [DW-1:0] e_sval,
    input logic          rep_set,
    input logic [LW-1:0] loop_left
);
    // R2: while running, the slot phase alternates every tick.
    assert_phase_alternates_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !halt |=> phase != $past(phase));

    // R2: writeback only happens in the closing tick of a slot.
    assert_write_in_phase1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> phase);

    // R5: a source read of the word being written gets the new value.
    assert_forward_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase && !halt && d_valid && !d_imm && wr_en && wr_addr == d_saddr)
        |=> e_sval == $past(wr_data));

    // R7: the remaining pass count never drops by more than one per step.
    assert_loop_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rep_set && loop_left != '0)
        |=> (loop_left == $past(loop_left) || loop_left == $past(loop_left) - 1'b1));

    // R8: halt is sticky.
    assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt);

    // R8: nothing is written once halted.
    assert_no_write_halted_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !wr_en);
endmodule

bind pipe_regcore rc_checker #(.AW(AW), .DW(DW), .LW(LW)) i_rc_checker (
    .clk(clk), .rst_n(rst_n), .phase(phase), .halt(halt),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .d_valid(d_valid), .d_imm(d_imm), .d_saddr(d_saddr),
    .e_sval(e_sval), .rep_set(rep_set), .loop_left(loop_left)
);

// File: tb/test_pipe_regcore.sv
// Bench for pipe_regcore: behavioural instruction-level reference model with
// delayed fetch visibility, per-clock halt comparison, full memory compare.
module test_pipe_regcore;
    localparam int CLK_PERIOD = 10;
    localparam int WORDS = 512;
    // Opcodes as stated in R3.
    localparam logic [4:0] K_NOP = 5'd0, K_MOV = 5'd1, K_ADD = 5'd2,
                           K_SETS = 5'd3, K_SETD = 5'd4, K_REP = 5'd5, K_HALT = 5'd6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pl_we = 1'b0;
    logic [8:0]  pl_addr = '0;
    logic [31:0] pl_data = '0;
    logic        halt;
    logic [8:0]  dbg_addr = '0;
    logic [31:0] dbg_data;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    logic [31:0] img [WORDS];
    logic [31:0] am  [WORDS];
    logic [31:0] fv  [WORDS];

    pipe_regcore i_pipe_regcore (
        .clk(clk), .rst_n(rst_n), .pl_we(pl_we), .pl_addr(pl_addr),
        .pl_data(pl_data), .halt(halt), .dbg_addr(dbg_addr), .dbg_data(dbg_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                bad++;
                total++;
                $display("FAIL watchdog act=%0d exp<=150000", cyc);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    function automatic logic [31:0] ins(input logic [4:0] op, input bit imm,
                                        input int d, input int s);
        return {op, 8'd0, imm, d[8:0], s[8:0]};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_img();
        for (int i = 0; i < WORDS; i++) img[i] = '0;
    endtask

    // Reference: executes in order on am; fetch sees writes of instructions
    // at least three issues old (fv). Returns issues before the stop.
    task automatic model_run(output int n);
        logic [41:0] q[$];
        logic [41:0] e;
        logic [31:0] w, dv, sv, res;
        logic [8:0]  pc, d, s, st, en;
        logic [4:0]  op;
        int          left;
        bit          wr;
        for (int i = 0; i < WORDS; i++) begin am[i] = img[i]; fv[i] = img[i]; end
        pc = 0; st = 0; en = 0; left = 0; n = 0;
        for (int g = 0; g < 5000; g++) begin
            while (q.size() > 2) begin
                e = q.pop_front();
                if (e[41]) fv[e[40:32]] = e[31:0];
            end
            w  = fv[pc];
            op = w[31:27];
            if (op == K_HALT) break;
            d  = w[17:9];
            s  = w[8:0];
            sv = w[18] ? {23'd0, s} : am[s];
            dv = am[d];
            wr = 1'b1;
            res = '0;
            case (op)
                K_MOV:  res = sv;
                K_ADD:  res = dv + sv;
                K_SETS: res = (dv & ~32'h1FF) | (sv & 32'h1FF);
                K_SETD: res = (dv & ~(32'h1FF << 9)) | ((sv & 32'h1FF) << 9);
                default: wr = 1'b0;
            endcase
            if (wr) am[d] = res;
            q.push_back({wr, d, res});
            n++;
            if (op == K_REP) begin
                st = pc + 1;
                en = pc + d;
                left = (sv[15:0] == 0) ? 0 : int'(sv[15:0]) - 1;
                pc = pc + 1;
            end else if (pc == en && left != 0) begin
                pc = st;
                left--;
            end else begin
                pc = pc + 1;
            end
        end
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        dbg_addr = a[8:0];
        #1;
        v = dbg_data;
    endtask

    // Preload, run and compare; first_run also checks the reset-state port view.
    task automatic run_case(input string name, input bit first_run);
        int n, exp_edges, edges, mism, first_halt;
        logic [31:0] v;
        model_run(n);
        exp_edges = 2 * n + 6;
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < WORDS; i++) begin
            pl_we = 1'b1; pl_addr = i[8:0]; pl_data = img[i];
            @(negedge clk);
        end
        pl_we = 1'b0;
        if (first_run) begin
            rd(100, v);
            chk("R1", "preloaded word visible in reset", v, img[100]);
            chk("R1", "halt low in reset", {31'd0, halt}, 32'd0);
            // A preload strobe with a different value after release must not land.
        end
        rst_n = 1'b1;
        edges = 0; mism = 0; first_halt = -1;
        while (edges < exp_edges + 6 && edges < 20000) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            if (halt !== (edges >= exp_edges)) mism++;
            if (halt === 1'b1 && first_halt < 0) first_halt = edges;
        end
        chk("R2", {name, " halt edge"}, first_halt, exp_edges);
        chk("R2", {name, " per-clock halt mismatches"}, mism, 0);
        mism = 0;
        for (int i = 0; i < WORDS; i++) begin
            rd(i, v);
            if (v !== am[i]) mism++;
        end
        chk("R6", {name, " words differing from model"}, mism, 0);
    endtask

    task automatic gather_prog(input bit lead_in);
        clear_img();
        for (int i = 0; i < 80; i++) img[100 + i] = 32'h1000 + i;
        img[20] = (32'd1 << 9) + 32'd8;
        img[0] = ins(K_SETS, 1, 4, 100);
        img[1] = ins(K_SETD, 1, 4, 200);
        img[2] = lead_in ? ins(K_ADD, 0, 4, 20) : ins(K_NOP, 0, 0, 0);
        img[3] = ins(K_REP, 1, 2, 9);
        img[4] = ins(K_MOV, 0, 0, 0);
        img[5] = ins(K_ADD, 0, 4, 20);
        img[6] = ins(K_HALT, 0, 0, 0);
    endtask

    initial begin
        logic [31:0] v;
        // R9 with lead-in: dst[k] = src[8k], 22 issues -> halt on edge 50 (R2, R7).
        gather_prog(1'b1);
        run_case("gather", 1'b1);
        for (int k = 0; k < 9; k++) begin
            rd(200 + k, v);
            chk("R9", $sformatf("gather dst[%0d]", k), v, 32'h1000 + 8 * k);
        end

        // R9 without lead-in: first element repeated, dst[8] never written (R6).
        gather_prog(1'b0);
        run_case("gather-nolead", 1'b0);
        for (int k = 0; k < 8; k++) begin
            rd(200 + k, v);
            chk("R9", $sformatf("nolead dst[%0d]", k), v, 32'h1000 + 8 * k);
        end
        rd(208, v);
        chk("R9", "nolead dst[8] untouched", v, 32'd0);

        // R5 forwarding chain; R3 add/copy with immediate and direct source.
        clear_img();
        img[40] = 32'd5;
        img[0] = ins(K_ADD, 1, 40, 1);
        img[1] = ins(K_ADD, 1, 40, 1);
        img[2] = ins(K_MOV, 0, 41, 40);
        img[3] = ins(K_ADD, 0, 41, 41);
        img[4] = ins(K_HALT, 0, 0, 0);
        run_case("forward", 1'b0);
        rd(40, v); chk("R5", "add after add", v, 32'd7);
        rd(41, v); chk("R3", "copy then self-add", v, 32'd14);

        // R6 visibility: patch 2 ahead is too late, 3 ahead takes effect.
        clear_img();
        img[0] = ins(K_SETD, 1, 2, 20);
        img[1] = ins(K_SETD, 1, 4, 21);
        img[2] = ins(K_MOV, 1, 10, 9'h55);
        img[3] = ins(K_NOP, 0, 0, 0);
        img[4] = ins(K_MOV, 1, 12, 9'h77);
        img[5] = ins(K_HALT, 0, 0, 0);
        run_case("selfmod", 1'b0);
        rd(10, v); chk("R6", "two-ahead patch ignored, old dest", v, 32'h55);
        rd(20, v); chk("R6", "two-ahead new dest untouched", v, 32'h0);
        rd(21, v); chk("R6", "three-ahead patch applied", v, 32'h77);
        rd(12, v); chk("R6", "three-ahead old dest untouched", v, 32'h0);

        // R7 zero count / memory count, R4 field inserts, R8 word after stop.
        clear_img();
        img[31] = 32'd3;
        img[34] = 32'hFFFF_FFFF;
        img[35] = 32'hFFFF_FFFF;
        img[0] = ins(K_REP, 1, 1, 0);
        img[1] = ins(K_ADD, 1, 30, 1);
        img[2] = ins(K_REP, 0, 2, 31);
        img[3] = ins(K_ADD, 1, 32, 2);
        img[4] = ins(K_ADD, 0, 33, 32);
        img[5] = ins(K_SETS, 1, 34, 0);
        img[6] = ins(K_SETD, 1, 35, 9'h1AB);
        img[7] = ins(K_HALT, 0, 0, 0);
        img[8] = ins(K_ADD, 1, 36, 1);
        run_case("loops", 1'b0);
        rd(30, v); chk("R7", "zero count runs once", v, 32'd1);
        rd(32, v); chk("R7", "three passes of add", v, 32'd6);
        rd(33, v); chk("R7", "running sum over passes", v, 32'd12);
        rd(34, v); chk("R4", "source field cleared only", v, 32'hFFFF_FE00);
        rd(35, v); chk("R4", "dest field replaced only", v, 32'hFFFF_57FF);
        rd(36, v); chk("R8", "word after stop has no effect", v, 32'd0);
        @(negedge clk);
        pl_we = 1'b1; pl_addr = 9'd37; pl_data = 32'hDEAD_BEEF;
        @(negedge clk);
        pl_we = 1'b0;
        rd(37, v); chk("R1", "preload ignored out of reset", v, 32'd0);
        chk("R8", "halt stays high", {31'd0, halt}, 32'd1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule